// File: doc/BRIEF.md
# Critical-Conduction PFC Switch Timer

This block drives the gate of the boost switch in a power-factor-correction stage that runs in critical-conduction mode. Each switching cycle has two parts. The gate is first held high for the currently programmed on-time. It is then held low until the inductor has emptied. The end of the low part is marked by a falling edge on the zero-current-detect input. Because the on-time is fixed within a cycle and the off-time lasts only as long as the inductor takes to discharge, the switching frequency runs freely.

A slow digital loop trims the on-time from two comparator flags on the DC bus. One flag says the bus is above target and the other says it is below. The loop moves the on-time by one small step, and only once every programmable number of completed switching cycles. The result is always kept inside a programmable window. If no zero-current edge arrives, a watchdog ends the off phase after a maximum off-time. Dropping enable turns the gate off at once and returns the on-time to its minimum.

Top module: `pfc_crm_timer`

## Requirements
- R1: While the gate is low in a running cycle, it rises again only on the clock edge that follows a falling edge of `zcd`. A falling edge means `zcd` was 1 at one clock edge and 0 at the next. When `zcd` last goes low D+1 clocks after the gate falls, the gate stays low for exactly D+2 clocks.
- R2: In every switching cycle the gate stays high for exactly `onTime` clock cycles. `onTime` does not change while the gate is high.
- R3: At an update point, `busHigh`=1 with `busLow`=0 lowers the on-time by `ON_STEP`. `busLow`=1 with `busHigh`=0 raises it by `ON_STEP`. Both flags set, or neither, leaves it unchanged.
- R4: The on-time never goes below `ON_MIN` or above `ON_MAX`. A step that would cross either limit lands exactly on that limit.
- R5: Update points come once every `UPD_CYCLES` completed switching cycles, counted from enable. The new value applies from the next on phase.
- R6: If no falling edge of `zcd` is seen, the off phase ends after exactly `OFF_MAX` clock cycles and a new on phase starts.
- R7: A `zcd` falling edge that occurs while the gate is high is ignored. It neither shortens nor extends that on phase.
- R8: When `en` is 0, `gate` is 0 in the same cycle, with no clock edge needed. From the next clock edge `onTime` equals `ON_MIN`, and the cycle-update count is cleared. After `en` returns to 1, the gate rises one clock later.
- R9: During reset, `gate` is 0 and `onTime` equals `ON_MIN`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low forces the gate off and resets the on-time |
| zcd | input | 1 | Zero-current-detect flag; its falling edge ends the off phase |
| busHigh | input | 1 | Bus voltage is above target |
| busLow | input | 1 | Bus voltage is below target |
| gate | output | 1 | Switch gate drive |
| onTime | output | TW | On-time in clock cycles currently in use |

## Verification
The embedded properties check four things on every cycle. The on-time stays inside its window. It is frozen while the gate is high. It sits at its minimum after enable has been low. Every return to the on phase is preceded by either a zero-current falling edge or a watchdog expiry. Only the bench scenarios can show that the pulse widths follow the step-and-clamp sequence of the loop across many cycles. They also show that off-times match the zero-current timing and the watchdog limit exactly, that zero-current edges during the on phase are ignored, and that dropping enable truncates a pulse in the same cycle.

// File: rtl/pfc_timer_pkg.sv
package pfc_timer_pkg;
  // Strobes from the sequencing control to the timing datapath.
  typedef struct packed {
    logic clrCnt;    // restart the phase counter
    logic cycleEnd;  // a full switching cycle has just completed
    logic hold;      // enable is low: park the loop at minimum
    logic gateOn;    // the on phase is active
  } ctl_strobe_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ON   = 2'd1,
    S_OFF  = 2'd2
  } pfc_state_t;
endpackage

// File: rtl/pfc_timer_dp.sv
module pfc_timer_dp
  import pfc_timer_pkg::*;
#(
  parameter int TW         = 12,
  parameter int ON_MIN     = 16,
  parameter int ON_MAX     = 1000,
  parameter int ON_STEP    = 1,
  parameter int UPD_CYCLES = 256,
  parameter int OFF_MAX    = 3000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_strobe_t   stb,
  input  logic          busHigh,
  input  logic          busLow,
  output logic          onDone,
  output logic          offTimeout,
  output logic [TW-1:0] onTimeQ
);
  localparam int OFF_W = $clog2(OFF_MAX + 1);
  localparam int CW    = (OFF_W > TW) ? OFF_W : TW;
  localparam int DW    = (UPD_CYCLES > 1) ? $clog2(UPD_CYCLES) : 1;

  logic [CW-1:0] phaseCnt;
  logic          update;
  logic [TW:0]   upSum;
  logic [TW-1:0] nextOn;

  // Shared phase counter: counts on-time, then off-time.
  always_ff @(posedge clk) begin
    if (!rst_n || stb.clrCnt) phaseCnt <= '0;
    else                      phaseCnt <= phaseCnt + CW'(1);
  end

  assign onDone     = (phaseCnt == CW'(onTimeQ) - CW'(1));
  assign offTimeout = (phaseCnt == CW'(OFF_MAX - 1));

  // Loop update divider: one update every UPD_CYCLES completed cycles.
  generate
    if (UPD_CYCLES > 1) begin : g_div
      logic [DW-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rst_n || stb.hold) divCnt <= '0;
        else if (stb.cycleEnd)
          divCnt <= (divCnt == DW'(UPD_CYCLES - 1)) ? '0 : divCnt + DW'(1);
      end
      assign update = stb.cycleEnd && (divCnt == DW'(UPD_CYCLES - 1));
    end else begin : g_nodiv
      assign update = stb.cycleEnd;
    end
  endgenerate

  // Step and clamp.
  assign upSum = {1'b0, onTimeQ} + (TW+1)'(ON_STEP);
  always_comb begin
    nextOn = onTimeQ;
    if (busHigh && !busLow)
      nextOn = (onTimeQ < TW'(ON_MIN + ON_STEP)) ? TW'(ON_MIN) : onTimeQ - TW'(ON_STEP);
    else if (busLow && !busHigh)
      nextOn = (upSum > (TW+1)'(ON_MAX)) ? TW'(ON_MAX) : upSum[TW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stb.hold) onTimeQ <= TW'(ON_MIN);
    else if (update)        onTimeQ <= nextOn;
  end

  a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
    (onTimeQ >= TW'(ON_MIN)) && (onTimeQ <= TW'(ON_MAX)));

  a_r2_frozen_on: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.gateOn && $past(stb.gateOn)) |-> $stable(onTimeQ));

  a_r8_park_min: assert property (@(posedge clk) disable iff (!rst_n)
    stb.hold |=> (onTimeQ == TW'(ON_MIN)));

  a_r5_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(onTimeQ) && !$past(stb.hold)) |-> $past(stb.cycleEnd));
endmodule

// File: rtl/pfc_timer_ctrl.sv
module pfc_timer_ctrl
  import pfc_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        zcd,
  input  logic        onDone,
  input  logic        offTimeout,
  output ctl_strobe_t stb
);
  pfc_state_t stateQ;
  logic       zcdPrev;
  logic       zcdFall;
  logic       offEnd;

  always_ff @(posedge clk) begin
    if (!rst_n) zcdPrev <= 1'b0;
    else        zcdPrev <= zcd;
  end

  // Falling edge only counts in the off phase.
  assign zcdFall = zcdPrev && !zcd;
  assign offEnd  = (stateQ == S_OFF) && (zcdFall || offTimeout);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) stateQ <= S_IDLE;
    else begin
      case (stateQ)
        S_IDLE:  stateQ <= S_ON;
        S_ON:    if (onDone) stateQ <= S_OFF;
        S_OFF:   if (zcdFall || offTimeout) stateQ <= S_ON;
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.hold     = !en;
    stb.gateOn   = (stateQ == S_ON);
    stb.cycleEnd = en && offEnd;
    stb.clrCnt   = !en || (stateQ == S_IDLE) || ((stateQ == S_ON) && onDone) || offEnd;
  end

  a_r1_restart_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ((stateQ == S_ON) && ($past(stateQ) == S_OFF)) |-> $past(zcdFall || offTimeout));

  a_r6_watchdog: assert property (@(posedge clk) disable iff (!rst_n)
    ((stateQ == S_OFF) && offTimeout && en) |=> (stateQ == S_ON));

  a_r7_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
    ((stateQ == S_ON) && !onDone && en) |=> (stateQ == S_ON));
endmodule

// File: rtl/pfc_crm_timer.sv
module pfc_crm_timer
  import pfc_timer_pkg::*;
#(
  parameter int TW         = 12,
  parameter int ON_MIN     = 16,
  parameter int ON_MAX     = 1000,
  parameter int ON_STEP    = 1,
  parameter int UPD_CYCLES = 256,
  parameter int OFF_MAX    = 3000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          zcd,
  input  logic          busHigh,
  input  logic          busLow,
  output logic          gate,
  output logic [TW-1:0] onTime
);
  ctl_strobe_t stb;
  logic        onDone;
  logic        offTimeout;

  pfc_timer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .zcd(zcd),
    .onDone(onDone), .offTimeout(offTimeout), .stb(stb)
  );

  pfc_timer_dp #(
    .TW(TW), .ON_MIN(ON_MIN), .ON_MAX(ON_MAX), .ON_STEP(ON_STEP),
    .UPD_CYCLES(UPD_CYCLES), .OFF_MAX(OFF_MAX)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .busHigh(busHigh), .busLow(busLow),
    .onDone(onDone), .offTimeout(offTimeout), .onTimeQ(onTime)
  );

  // Enable gates the drive directly so a drop acts without a clock edge.
  assign gate = en && stb.gateOn;
endmodule

// File: tb/sim_pfc_crm_timer.sv
module sim_pfc_crm_timer;
  localparam int TW = 8, ON_MIN = 4, ON_MAX = 12, ON_STEP = 2, UPD = 4, OFF_MAX = 40;

  logic clk = 0, rst_n = 0, en = 0, zcd = 0, busHigh = 0, busLow = 0;
  logic gate;
  logic [TW-1:0] onTime;

  int checks = 0, errors = 0;
  int expQ[$];
  int ot = ON_MIN, cyc = 0;
  int zDelay = 3;
  bit glitch = 0;
  int expGap = 5;
  string gapReq = "R1";
  string pulseReq = "R2";
  bit monEn = 0, firstGap = 1, prevG = 0;
  int hiLen = 0, lowLen = 0;

  always #4 clk = ~clk;

  pfc_crm_timer #(.TW(TW), .ON_MIN(ON_MIN), .ON_MAX(ON_MAX), .ON_STEP(ON_STEP),
                  .UPD_CYCLES(UPD), .OFF_MAX(OFF_MAX)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .zcd(zcd), .busHigh(busHigh),
    .busLow(busLow), .gate(gate), .onTime(onTime));

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Zero-current stimulus: falling edge D+1 clocks after gate falls; optional glitch in the on phase.
  initial begin
    bit p = 0;
    forever begin
      @(negedge clk);
      if (p && !gate && en && zDelay >= 0) begin
        repeat (zDelay) @(negedge clk);
        zcd = 1;
        @(negedge clk);
        zcd = 0;
      end else if (!p && gate && glitch) begin
        zcd = 1;
        @(negedge clk);
        zcd = 0;
      end
      p = gate;
    end
  end

  // Monitor: pops expected pulse widths, checks off-times.
  always @(negedge clk) begin
    if (monEn) begin
      if (gate) begin
        if (!prevG) begin
          if (!firstGap) check(lowLen == expGap, gapReq, lowLen, expGap);
          firstGap = 0;
          lowLen = 0;
        end
        hiLen++;
      end else begin
        if (prevG) begin
          if (expQ.size() == 0) check(0, "R2 unexpected pulse", hiLen, 0);
          else begin
            int e;
            e = expQ.pop_front();
            check(hiLen == e, pulseReq, hiLen, e);
          end
          hiLen = 0;
        end
        lowLen++;
      end
      prevG = gate;
    end
  end

  // Driver: applies flags, pushes expected widths from the loop model, waits for completion.
  task automatic runPhase(int n, bit hi, bit lo, int dly, bit gl, string req);
    busHigh = hi; busLow = lo; zDelay = dly; glitch = gl; pulseReq = req;
    expGap = (dly < 0) ? OFF_MAX : dly + 2;
    gapReq = (dly < 0) ? "R6" : "R1";
    for (int i = 0; i < n; i++) begin
      expQ.push_back(ot);
      cyc++;
      if (cyc % UPD == 0) begin
        if (hi && !lo) ot = (ot - ON_STEP < ON_MIN) ? ON_MIN : ot - ON_STEP;
        else if (lo && !hi) ot = (ot + ON_STEP > ON_MAX) ? ON_MAX : ot + ON_STEP;
      end
    end
    do begin @(negedge clk); #1; end while (expQ.size() != 0 || gate != 1'b1);
    check(int'(onTime) == ot, {req, " R4 onTime after phase"}, onTime, ot);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(gate == 0, "R9 gate in reset", gate, 0);
    check(int'(onTime) == ON_MIN, "R9 onTime in reset", onTime, ON_MIN);
    rst_n = 1;
    @(negedge clk); #1;
    check(gate == 0, "R8 gate idle while disabled", gate, 0);
    monEn = 1;
    en = 1;
    runPhase(6, 0, 0, 3, 0, "R2 steady");
    runPhase(24, 0, 1, 3, 0, "R3 R5 raise to clamp");
    runPhase(28, 1, 0, 3, 0, "R3 R4 lower to clamp");
    runPhase(8, 1, 1, 3, 0, "R3 both flags hold");
    runPhase(8, 0, 1, 6, 1, "R7 zcd during on");
    runPhase(5, 0, 0, -1, 0, "R6 watchdog");
    // Enable drop in the middle of a pulse.
    runPhase(2, 0, 0, 3, 0, "R2 before disable");
    @(negedge clk); #1;
    monEn = 0;
    en = 0;
    #1;
    check(gate == 0, "R8 gate drops with enable", gate, 0);
    @(negedge clk); #1;
    check(int'(onTime) == ON_MIN, "R8 onTime back to minimum", onTime, ON_MIN);
    repeat (3) begin
      @(negedge clk); #1;
      check(gate == 0, "R8 gate stays low while disabled", gate, 0);
    end
    expQ.delete();
    ot = ON_MIN; cyc = 0;
    prevG = 0; hiLen = 0; lowLen = 0; firstGap = 1;
    monEn = 1;
    en = 1;
    @(negedge clk); #1;
    check(gate == 1, "R8 gate rises one clock after enable", gate, 1);
    expQ.push_back(ot); cyc++;
    runPhase(8, 0, 1, 3, 0, "R5 after re-enable");
    monEn = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule